// File: doc/BRIEF.md
# Vector-length CSR read rewriter

This block sits in the instruction decode stage and turns reads of the vector-length CSR into ordinary scalar register moves. It keeps a small pointer, one register index wide, that names the scalar register currently acting as the vector length. Every incoming instruction word is inspected. If the word is a CSR read of the vector-length CSR and the pointer does not name x0, the word is replaced by a move from the named register into the same destination. Because the result is a plain integer instruction, the scalar scoreboard tracks it like any other register read, and no CSR-specific stall is needed.

The pointer is loaded through an update port with a valid strobe. An update that arrives in the same cycle as a decode takes effect for that decode. The rewritten (or untouched) word and a flag reporting the substitution leave the block one clock after the instruction enters. Executing the move belongs to later stages.

Top module: `vl_csrr_rewriter`

## Requirements
- R1: After reset the pointer names x0, and out_valid and out_subst are low until an instruction is accepted.
- R2: A word counts as a vector-length read only when bits [6:0] are 1110011, bits [14:12] are 010, bits [19:15] are zero and bits [31:20] equal the parameter VL_CSR_ADDR (default 0xC20). The destination field in bits [11:7] may hold any value.
- R3: When a vector-length read is seen and the pointer is not x0, the output word is {12'h000, pointer, 3'b000, rd, 7'b0010011}. That is an add-immediate of zero from the pointed register into the original rd, so it carries no CSR address. out_subst is high.
- R4: When a vector-length read is seen and the pointer is x0, the word passes through unchanged and out_subst is low.
- R5: Every word that is not a vector-length read passes through unchanged with out_subst low. This includes words for other CSRs, words with a nonzero bits [19:15] and words with another funct3.
- R6: When upd_valid is high at a clock edge, the pointer takes upd_idx. Otherwise it keeps its value.
- R7: When upd_valid and in_valid are both high in a cycle, that cycle's decision uses upd_idx rather than the old pointer.
- R8: out_valid, out_inst and out_subst are registered. They reflect the in_valid and in_inst sampled at the previous clock edge, and out_subst is never high while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_inst | input | 32 | Instruction word from fetch |
| upd_valid | input | 1 | Load the vector-length register pointer |
| upd_idx | input | 5 | New pointer value |
| out_valid | output | 1 | Output word valid |
| out_inst | output | 32 | Rewritten or unchanged instruction word |
| out_subst | output | 1 | The output word is a substituted move |

## Verification
A pointer update and the decode of a vector-length read can fall in the same cycle. The bench provokes this both in directed steps and in a random phase: it loads a new index together with a matching read, and also together with a non-matching word and with an x0 index. Its reference model applies the update before it judges the instruction. The expected word therefore names the fresh register, or passes through untouched when the fresh index is x0, and the bench compares this with the block's output one clock later.

// File: rtl/vlrw_pkg.sv
package vlrw_pkg;
  localparam int INST_W = 32;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [2:0] F3_CSRRS   = 3'b010;
  localparam logic [2:0] F3_ADDI    = 3'b000;

  typedef logic [INST_W-1:0] inst_t;

  // True when the word reads csr_addr without side effect
  function automatic logic csr_plain_read(inst_t w, logic [11:0] csr_addr);
    return (w[6:0] == OPC_SYSTEM) && (w[14:12] == F3_CSRRS) &&
           (w[19:15] == 5'd0) && (w[31:20] == csr_addr);
  endfunction

  // Add-immediate zero: rd <- src
  function automatic inst_t move_word(logic [4:0] rd, logic [4:0] src);
    return {12'h000, src, F3_ADDI, rd, OPC_OPIMM};
  endfunction
endpackage

// File: rtl/vlrw_ptr_cache.sv
module vlrw_ptr_cache #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [IDX_W-1:0] eff_idx
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (upd_valid) ptr_q <= upd_idx;
  end

  // write-through: a same-cycle update is seen by the decode
  assign eff_idx = upd_valid ? upd_idx : ptr_q;

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ptr_q));
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ptr_q == $past(upd_idx));
endmodule

// File: rtl/vlrw_detect.sv
module vlrw_detect
  import vlrw_pkg::*;
#(
  parameter logic [11:0] CSR_ADDR = 12'hC20
) (
  input  inst_t      inst,
  output logic       is_vl_read,
  output logic [4:0] rd
);
  assign is_vl_read = csr_plain_read(inst, CSR_ADDR);
  assign rd         = inst[11:7];
endmodule

// File: rtl/vlrw_move_gen.sv
module vlrw_move_gen
  import vlrw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             is_vl_read,
  input  logic [4:0]       rd,
  input  logic [IDX_W-1:0] src_idx,
  input  inst_t            inst,
  output logic             take_move,
  output inst_t            new_inst
);
  assign take_move = is_vl_read && (src_idx != '0);
  assign new_inst  = take_move ? move_word(rd, src_idx) : inst;
endmodule

// File: rtl/vl_csrr_rewriter.sv
module vl_csrr_rewriter
  import vlrw_pkg::*;
#(
  parameter int          IDX_W       = 5,
  parameter logic [11:0] VL_CSR_ADDR = 12'hC20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_inst,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  output logic             out_valid,
  output logic [31:0]      out_inst,
  output logic             out_subst
);
  // named internal events for the assertions
  logic [IDX_W-1:0] eff_idx;
  logic             is_vl_read;
  logic [4:0]       rd_f;
  logic             take_move;
  inst_t            new_inst;

  vlrw_ptr_cache #(.IDX_W(IDX_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
    .upd_idx(upd_idx), .eff_idx(eff_idx)
  );

  vlrw_detect #(.CSR_ADDR(VL_CSR_ADDR)) u_detect (
    .inst(in_inst), .is_vl_read(is_vl_read), .rd(rd_f)
  );

  vlrw_move_gen #(.IDX_W(IDX_W)) u_move (
    .is_vl_read(is_vl_read), .rd(rd_f), .src_idx(eff_idx),
    .inst(in_inst), .take_move(take_move), .new_inst(new_inst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_inst  <= '0;
      out_subst <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_inst  <= new_inst;
      out_subst <= in_valid && take_move;
    end
  end

  assert_subst_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_subst |-> out_valid);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  assert_move_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_subst |-> (out_inst[6:0] == OPC_OPIMM && out_inst[31:20] == 12'h000
                   && out_inst[14:12] == F3_ADDI));
  assert_rd_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_subst |-> out_inst[11:7] == $past(in_inst[11:7]));
  assert_no_x0_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_subst |-> out_inst[19:15] != 5'd0);
  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_subst) |-> out_inst == $past(in_inst));
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_subst && $past(upd_valid)) |-> out_inst[19:15] == 5'($past(upd_idx)));
endmodule

// File: tb/vl_csrr_rewriter_tb.sv
module vl_csrr_rewriter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_inst = '0;
  logic        upd_valid = 1'b0;
  logic [4:0]  upd_idx = '0;
  logic        out_valid;
  logic [31:0] out_inst;
  logic        out_subst;

  int checks = 0;
  int fails  = 0;
  int ref_ptr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vl_csrr_rewriter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inst(in_inst),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .out_valid(out_valid),
    .out_inst(out_inst), .out_subst(out_subst)
  );

  function automatic logic [31:0] csr_word(int csr, int rs1, int f3, int rd);
    return (32'(csr) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'h73;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one decode cycle; reference applies update before judging
  task automatic step(bit iv, logic [31:0] w, bit uv, int ui, string req);
    int ptr;
    bit hit;
    logic [31:0] exp_w;
    @(negedge clk);
    in_valid = iv; in_inst = w; upd_valid = uv; upd_idx = 5'(ui);
    ptr = uv ? ui : ref_ptr;
    hit = (w & 32'hFFF_FF07F) == 32'hC200_2073 && ptr != 0;
    exp_w = hit ? ((32'(ptr) << 15) | (w & 32'h0000_0F80) | 32'h13) : w;
    @(posedge clk);
    ref_ptr = ptr;
    #2;
    check({req, " valid"}, 32'(out_valid), 32'(iv));
    check({req, " flag"}, 32'(out_subst), 32'(iv && hit));
    check({req, " word"}, out_inst, exp_w);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset valid", 32'(out_valid), 32'h0);
    check("R1 reset flag", 32'(out_subst), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R1: pointer starts at x0, so read passes
    step(1, csr_word(12'hC20, 0, 2, 7), 0, 0, "R1 x0 after reset");
    // R6: load pointer, then R3 substitution
    step(0, 32'h0000_0013, 1, 9, "R6 load idle");
    step(1, csr_word(12'hC20, 0, 2, 7), 0, 0, "R3 substitute");
    step(1, csr_word(12'hC20, 0, 2, 31), 0, 0, "R3 rd31");
    step(1, csr_word(12'hC20, 0, 2, 0), 0, 0, "R2 rd x0 still matches");
    // R5: near misses
    step(1, csr_word(12'hC21, 0, 2, 7), 0, 0, "R5 other csr");
    step(1, csr_word(12'hC20, 3, 2, 7), 0, 0, "R5 rs1 nonzero");
    step(1, csr_word(12'hC20, 0, 3, 7), 0, 0, "R5 funct3 other");
    step(1, csr_word(12'hC20, 0, 2, 7) ^ 32'h4, 0, 0, "R2 opcode bit");
    // R8: invalid input gives no flag
    step(0, csr_word(12'hC20, 0, 2, 5), 0, 0, "R8 invalid");
    // R7: same-cycle bypass
    step(1, csr_word(12'hC20, 0, 2, 4), 1, 17, "R7 bypass new idx");
    step(1, csr_word(12'hC20, 0, 2, 4), 0, 0, "R6 held idx");
    step(1, csr_word(12'hC20, 0, 2, 4), 1, 0, "R4 bypass to x0");
    step(1, csr_word(12'hC20, 0, 2, 4), 0, 0, "R4 x0 pass");
    step(1, csr_word(12'h300, 0, 2, 4), 1, 2, "R7 update with non-match");
    step(1, csr_word(12'hC20, 0, 2, 6), 0, 0, "R6 after update");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int sel = $urandom_range(0, 3);
      if (sel == 0) w = $urandom;
      else w = csr_word((sel == 1) ? 12'hC20 : $urandom_range(12'hC1F, 12'hC21),
                        ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : 0,
                        ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 2,
                        $urandom_range(0, 31));
      step($urandom_range(0, 7) != 0, w, $urandom_range(0, 3) == 0,
           ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 31), "R7 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule